// File: doc/BRIEF.md
# Serial Stereo Audio Receiver

This block is the receive side of a three-wire serial audio link. It runs as a slave: bit clock, word select and data all come from an external transmitter. The three lines are resynchronised into the system clock domain, and a rising edge of the bit clock is detected there. Each detected edge samples one data bit. The block splits the stream into left and right slots. When a complete left-then-right pair has been collected, it delivers both samples together on a parallel bus for one system clock cycle.

Two control inputs set how the stream is read. The first picks the frame alignment. In the standard alignment the most significant bit follows the word-select change by one bit clock. In the left-justified alignment the most significant bit arrives on the same edge as the change. The second picks a sample length of 16 or 32 bits. The transmitter's bit clock may be 32 or 64 times the sample rate, which gives slots of 16 or 32 bits. The block handles either slot width with either sample length. Both controls are expected to be static while a stream is running, and are normally set while the block is held in reset.

Top module: `i2s_stereo_rx`

## Requirements
- R1: While reset is held and after it is released, with no stream present, `valid_o` is 0 and both `left_o` and `right_o` read 0.
- R2: With `fmt_lj_i` = 0 (standard alignment), the bit sampled on the bit-clock rising edge after the one where word select is first seen at its new level is taken as the most significant bit of the new slot.
- R3: With `fmt_lj_i` = 1 (left-justified), the bit sampled on the same bit-clock rising edge where word select is first seen at its new level is taken as the most significant bit of the new slot.
- R4: A slot transmitted with word select low is reported on `left_o`, and a slot transmitted with word select high is reported on `right_o`.
- R5: Bits arrive most significant first. Each sample is presented MSB-aligned in the 32-bit output field: bit 31 holds the first bit received.
- R6: When the slot is wider than the selected length (`wlen32_i` = 0 selects 16 bits, 1 selects 32 bits), the bits that follow the selected length are ignored. Output bits below the sample read 0.
- R7: When the slot is narrower than the selected length, the output bits below the received ones read 0.
- R8: `valid_o` goes high for exactly one system clock cycle per frame, and only once a left slot followed by a right slot has been captured. `left_o` and `right_o` change only in that cycle. The pulse appears once the following slot has begun.
- R9: Bit clocks of 32 and 64 times the sample rate (16-bit and 32-bit slots) are both received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be well above twice the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bclk_i | input | 1 | Serial bit clock from the transmitter |
| ws_i | input | 1 | Word select: low for left, high for right |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_lj_i | input | 1 | 0 = standard one-bit-delayed alignment, 1 = left-justified |
| wlen32_i | input | 1 | 0 = 16-bit samples, 1 = 32-bit samples |
| left_o | output | 32 | Left sample, MSB-aligned |
| right_o | output | 32 | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe marking a new stereo pair |

## Verification
A fault in the slot framing shows up as a wrong output value within the same frame. A start edge detected one bit late or early shifts every bit of the sample by one place. A bad channel decision swaps the two outputs, or removes the frame's valid pulse altogether. A bit counter that runs past the selected length puts received bits into the low bits, which must read zero. This is visible at the first strobe of a run whose slot is wider than the sample. The pairing state is observed through the number of strobes: a leftover left half turns into an extra or a missing pulse at the next right slot.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

  typedef enum logic {
    ALIGN_STD = 1'b0,
    ALIGN_LJ  = 1'b1
  } align_e;

  typedef struct packed {
    logic bclk;
    logic ws;
    logic sd;
  } line_set_t;

endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync
  import i2s_rx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic rise_o,
  output logic ws_o,
  output logic sd_o
);

  line_set_t stage_q [STAGES];
  line_set_t stage_n [STAGES];
  logic      bclk_prev_q;
  logic      bclk_prev_n;

  // all three lines share one pipeline so their relative timing is preserved
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_n[g] = '{bclk: bclk_i, ws: ws_i, sd: sd_i};
      end else begin : g_next
        always_comb stage_n[g] = stage_q[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_n[g];
      end
    end
  endgenerate

  always_comb bclk_prev_n = stage_q[STAGES-1].bclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev_q <= 1'b0;
    else        bclk_prev_q <= bclk_prev_n;
  end

  always_comb begin
    rise_o = stage_q[STAGES-1].bclk & ~bclk_prev_q;
    ws_o   = stage_q[STAGES-1].ws;
    sd_o   = stage_q[STAGES-1].sd;
  end

  // R9: a detected bit-clock edge never lasts two system cycles
  p_rise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/i2s_rx_slot.sv
module i2s_rx_slot
  import i2s_rx_pkg::*;
#(
  parameter int MAX_W   = 32,
  parameter int SHORT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             ws_i,
  input  logic             sd_i,
  input  align_e           align_i,
  input  logic             wlen32_i,
  output logic             commit_o,
  output logic             commit_right_o,
  output logic [MAX_W-1:0] commit_word_o
);

  localparam int CW = $clog2(MAX_W + 1);
  localparam int IW = $clog2(MAX_W);
  localparam int PAD_W = MAX_W - SHORT_W;

  logic             ws_d_q, ws_d_n;
  logic             ws_dd_q, ws_dd_n;
  logic [MAX_W-1:0] acc_q, acc_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             live_q, live_n;

  logic             chan_now;
  logic             chan_prev;
  logic             slot_start;
  logic [CW-1:0]    limit;
  logic [IW-1:0]    bit_idx;

  // the channel owning the current bit: left-justified uses word select as
  // sampled, the standard alignment uses the level from one bit earlier
  always_comb begin
    if (align_i == ALIGN_LJ) begin
      chan_now  = ws_i;
      chan_prev = ws_d_q;
    end else begin
      chan_now  = ws_d_q;
      chan_prev = ws_dd_q;
    end
    slot_start = rise_i & (chan_now ^ chan_prev);
    limit      = wlen32_i ? CW'(MAX_W) : CW'(SHORT_W);
    bit_idx    = IW'(MAX_W - 1) - cnt_q[IW-1:0];
  end

  always_comb begin
    ws_d_n  = ws_d_q;
    ws_dd_n = ws_dd_q;
    acc_n   = acc_q;
    cnt_n   = cnt_q;
    live_n  = live_q;
    if (rise_i) begin
      ws_d_n  = ws_i;
      ws_dd_n = ws_d_q;
      if (slot_start) begin
        acc_n          = '0;
        acc_n[MAX_W-1] = sd_i;
        cnt_n          = CW'(1);
        live_n         = 1'b1;
      end else if (cnt_q < limit) begin
        acc_n[bit_idx] = sd_i;
        cnt_n          = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_d_q  <= 1'b0;
      ws_dd_q <= 1'b0;
      acc_q   <= '0;
      cnt_q   <= '0;
      live_q  <= 1'b0;
    end else if (rise_i) begin
      ws_d_q  <= ws_d_n;
      ws_dd_q <= ws_dd_n;
      acc_q   <= acc_n;
      cnt_q   <= cnt_n;
      live_q  <= live_n;
    end
  end

  // a slot is handed over when the next one starts
  always_comb begin
    commit_o       = slot_start & live_q;
    commit_right_o = chan_prev;
    commit_word_o  = acc_q;
  end

  // R9: the bit counter never runs past the widest slot
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_W));

  // R6: a short sample leaves the low part of a handed-over word clear
  p_short_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o && !wlen32_i) |-> (commit_word_o[PAD_W-1:0] == '0));

  // R2: a handed-over slot always follows a bit-clock edge
  p_commit_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> rise_i);

endmodule

// File: rtl/i2s_rx_pair.sv
module i2s_rx_pair #(
  parameter int MAX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic             commit_right_i,
  input  logic [MAX_W-1:0] commit_word_i,
  output logic [MAX_W-1:0] left_o,
  output logic [MAX_W-1:0] right_o,
  output logic             valid_o
);

  logic [MAX_W-1:0] left_hold_q, left_hold_n;
  logic             have_left_q, have_left_n;
  logic [MAX_W-1:0] left_q, left_n;
  logic [MAX_W-1:0] right_q, right_n;
  logic             valid_q, valid_n;

  always_comb begin
    left_hold_n = left_hold_q;
    have_left_n = have_left_q;
    left_n      = left_q;
    right_n     = right_q;
    valid_n     = 1'b0;
    if (commit_i) begin
      if (!commit_right_i) begin
        left_hold_n = commit_word_i;
        have_left_n = 1'b1;
      end else begin
        if (have_left_q) begin
          left_n  = left_hold_q;
          right_n = commit_word_i;
          valid_n = 1'b1;
        end
        have_left_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      left_q      <= '0;
      right_q     <= '0;
      valid_q     <= 1'b0;
    end else begin
      left_hold_q <= left_hold_n;
      have_left_q <= have_left_n;
      left_q      <= left_n;
      right_q     <= right_n;
      valid_q     <= valid_n;
    end
  end

  always_comb begin
    left_o  = left_q;
    right_o = right_q;
    valid_o = valid_q;
  end

  // R8: the strobe is a single-cycle pulse
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R8: outputs only move together with the strobe
  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R4: a pair is only emitted when a right slot is handed over
  p_pair_on_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(commit_i && commit_right_i));

endmodule

// File: rtl/i2s_stereo_rx.sv
module i2s_stereo_rx
  import i2s_rx_pkg::*;
#(
  parameter int MAX_W       = 32,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk_i,
  input  logic        ws_i,
  input  logic        sd_i,
  input  logic        fmt_lj_i,
  input  logic        wlen32_i,
  output logic [31:0] left_o,
  output logic [31:0] right_o,
  output logic        valid_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic             rise;
  logic             ws_s;
  logic             sd_s;
  logic             commit;
  logic             commit_right;
  logic [MAX_W-1:0] commit_word;
  logic [MAX_W-1:0] left_w;
  logic [MAX_W-1:0] right_w;
  align_e           align;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign align = fmt_lj_i ? ALIGN_LJ : ALIGN_STD;

  i2s_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .bclk_i (bclk_i),
    .ws_i   (ws_i),
    .sd_i   (sd_i),
    .rise_o (rise),
    .ws_o   (ws_s),
    .sd_o   (sd_s)
  );

  i2s_rx_slot #(.MAX_W(MAX_W), .SHORT_W(SHORT_W)) u_slot (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .rise_i         (rise),
    .ws_i           (ws_s),
    .sd_i           (sd_s),
    .align_i        (align),
    .wlen32_i       (wlen32_i),
    .commit_o       (commit),
    .commit_right_o (commit_right),
    .commit_word_o  (commit_word)
  );

  i2s_rx_pair #(.MAX_W(MAX_W)) u_pair (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .commit_i       (commit),
    .commit_right_i (commit_right),
    .commit_word_i  (commit_word),
    .left_o         (left_w),
    .right_o        (right_w),
    .valid_o        (valid_o)
  );

  generate
    if (MAX_W >= 32) begin : g_out_trim
      assign left_o  = left_w[MAX_W-1 -: 32];
      assign right_o = right_w[MAX_W-1 -: 32];
    end else begin : g_out_pad
      assign left_o  = {left_w,  {(32-MAX_W){1'b0}}};
      assign right_o = {right_w, {(32-MAX_W){1'b0}}};
    end
  endgenerate

  // R1: no strobe during or straight after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |=> !valid_o);

endmodule

// File: tb/tb_i2s_stereo_rx.sv
module tb_i2s_stereo_rx;

  logic        clk;
  logic        rst_n;
  logic        bclk_i;
  logic        ws_i;
  logic        sd_i;
  logic        fmt_lj_i;
  logic        wlen32_i;
  logic [31:0] left_o;
  logic [31:0] right_o;
  logic        valid_o;

  int checks;
  int fails;
  int mon_checks;
  int mon_fails;
  bit done;

  localparam int NF  = 3;
  localparam int PRE = 3;

  logic [31:0] tx_l [NF];
  logic [31:0] tx_r [NF];
  logic [31:0] cap_l [8];
  logic [31:0] cap_r [8];
  int          ncap;
  logic        valid_prev;

  i2s_stereo_rx dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_i   (bclk_i),
    .ws_i     (ws_i),
    .sd_i     (sd_i),
    .fmt_lj_i (fmt_lj_i),
    .wlen32_i (wlen32_i),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // strobe monitor, sampled on the inactive edge
  always @(negedge clk) begin
    if (valid_o) begin
      if (ncap < 8) begin
        cap_l[ncap] = left_o;
        cap_r[ncap] = right_o;
      end
      ncap = ncap + 1;
      mon_checks = mon_checks + 1;
      if (valid_prev) begin
        mon_fails = mon_fails + 1;
        $display("FAIL R8: strobe held high, actual 2+ cycles expected 1");
      end
    end
    valid_prev = valid_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic lj, input logic w32);
    @(negedge clk);
    rst_n    = 1'b0;
    bclk_i   = 1'b0;
    ws_i     = 1'b0;
    sd_i     = 1'b0;
    fmt_lj_i = lj;
    wlen32_i = w32;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ncap       = 0;
    valid_prev = 1'b0;
  endtask

  function automatic logic chan_at(int q, int slot);
    if (q < PRE) return 1'b1;
    if (q >= PRE + NF*2*slot) return 1'b0;
    return ((q - PRE) % (2*slot)) >= slot;
  endfunction

  function automatic logic data_at(int q, int slot);
    int p, f, j;
    if (q < PRE || q >= PRE + NF*2*slot) return 1'b0;
    p = (q - PRE) % (2*slot);
    f = (q - PRE) / (2*slot);
    j = p % slot;
    if (p < slot) return tx_l[f][31-j];
    return tx_r[f][31-j];
  endfunction

  task automatic send_bit(input logic ws, input logic sd);
    bclk_i = 1'b0;
    ws_i   = ws;
    sd_i   = sd;
    repeat (4) @(negedge clk);
    bclk_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // sends a lead-in right slot, NF frames, then a short left slot
  task automatic stream(input logic lj, input int slot);
    int total;
    total = PRE + NF*2*slot + PRE;
    for (int q = 0; q < total; q++) begin
      send_bit(lj ? chan_at(q, slot) : chan_at(q + 1, slot), data_at(q, slot));
    end
    bclk_i = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic run_case(input string req, input logic lj, input int slot,
                          input logic w32, input logic [31:0] seed);
    int n;
    logic [31:0] mask;
    n    = (w32 ? 32 : 16);
    if (slot < n) n = slot;
    mask = 32'hFFFF_FFFF << (32 - n);
    for (int f = 0; f < NF; f++) begin
      tx_l[f] = seed ^ (32'h1357_9BDF * (f + 1)) ^ 32'h8000_0001;
      tx_r[f] = ~seed ^ (32'h2468_ACE1 * (f + 3)) ^ 32'h0001_8001;
    end
    do_reset(lj, w32);
    stream(lj, slot);
    check({req, " R8 strobe count"}, 32'(ncap), 32'(NF));
    for (int f = 0; f < NF && f < ncap; f++) begin
      check({req, " R4 left"},  cap_l[f], tx_l[f] & mask);
      check({req, " R4 right"}, cap_r[f], tx_r[f] & mask);
    end
  endtask

  task automatic t_reset_r1;
    do_reset(1'b0, 1'b1);
    check("R1 valid", {31'b0, valid_o}, 32'd0);
    check("R1 left",  left_o,  32'd0);
    check("R1 right", right_o, 32'd0);
  endtask

  // R2 R5 R9: standard alignment, 32-bit slots, 32-bit samples
  task automatic t_std_wide_r2;
    run_case("R2 R5", 1'b0, 32, 1'b1, 32'hC0DE_5A17);
  endtask

  // R3: left-justified alignment, 32-bit slots
  task automatic t_lj_wide_r3;
    run_case("R3", 1'b1, 32, 1'b1, 32'h9E37_79B9);
  endtask

  // R9: 32x bit clock (16-bit slots) with 16-bit samples
  task automatic t_std_narrow_r9;
    run_case("R9", 1'b0, 16, 1'b0, 32'hF00D_BEEF);
  endtask

  // R6: 32-bit slots, 16-bit samples, trailing bits ignored
  task automatic t_wide_slot_r6;
    run_case("R6", 1'b0, 32, 1'b0, 32'h7FFF_FFFF);
  endtask

  // R7: 16-bit slots, 32-bit samples, missing bits zero
  task automatic t_narrow_slot_r7;
    run_case("R7", 1'b1, 16, 1'b1, 32'h0F1E_2D3C);
  endtask

  initial begin
    checks = 0; fails = 0; mon_checks = 0; mon_fails = 0; done = 0;
    ncap = 0; valid_prev = 1'b0;
    rst_n = 1'b0; bclk_i = 1'b0; ws_i = 1'b0; sd_i = 1'b0;
    fmt_lj_i = 1'b0; wlen32_i = 1'b1;
    t_reset_r1();
    t_std_wide_r2();
    t_lj_wide_r3();
    t_std_narrow_r9();
    t_wide_slot_r6();
    t_narrow_slot_r7();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
             checks + mon_checks, fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
               checks + mon_checks + 1, fails + mon_fails + 1);
      $finish;
    end
  end

endmodule